// File: doc/BRIEF.md
# Interrupt Output Throttling Controller

This block drives one external interrupt request pin from a group of internal interrupt sources. Each source arrives as a status bit paired with an enable bit. The block ORs the enabled sources into a master request. It then holds that request back for a programmable quiet time after every deassertion of the pin. Finally it applies a global enable, a polarity choice and a push-pull or open-drain drive style. A separate wake-event source is exempt from the quiet time: when it is enabled, it reaches the pin at once.

Software controls the block through a single 32-bit register behind a simple write strobe with combinational read data. The quiet time is an 8-bit count of 10 µs units. A prescaler derived from the clock-frequency parameter marks those units. Software can restart the quiet time at any moment. Writing a zero count cancels the quiet time and releases any request being held. A live flag shows whether a quiet time is in progress. The asynchronous reset input is released into the block synchronously, through two flops.

Top module: `irq_throttle`

## Requirements
- R1: Register layout. Bits [31:24] are the interval count, bit 8 is the pin enable and bit 4 is the polarity; all three are writable and reset to 0. Bit 14 is the restart control and always reads 0. Bit 13 is the interval-running flag and bit 12 is the master interrupt. Every other bit reads 0.
- R2: Bit 12 reads the OR of `src_status & src_enable` in the same cycle. Neither the pin enable nor a running interval changes it.
- R3: An interval starts on the clock edge at which the pin request drops while it was registered as asserted. It loads the programmed count and lasts count × (CLK_FREQ_HZ/100000) cycles. Bit 13 reads 1 throughout.
- R4: While an interval runs, enabled non-wake sources do not reach the pin. If a source is still pending when the interval ends, the pin asserts one cycle after bit 13 returns to 0.
- R5: Writing 1 to bit 14 reloads the counter from the written count field and restarts the unit timer, whether or not an interval is running.
- R6: A write whose count field is 0 ends any running interval at that edge, and pending sources reach the pin on the following edge.
- R7: When the pin enable is 0, the pin stays deasserted.
- R8: In push-pull mode (`od_mode`=0), `irq_oe` is 1. `irq_out` is active low when polarity=0 and active high when polarity=1.
- R9: In open-drain mode (`od_mode`=1), `irq_out` is 0 at all times and `irq_oe` is 1 only while the request is asserted, whatever the polarity.
- R10: An enabled wake event reaches the pin even while an interval runs.
- R11: The pin state is registered. It follows the gated request one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| src_status | input | N_SRC | Internal interrupt status bits |
| src_enable | input | N_SRC | Per-source enables |
| wake_status | input | 1 | Wake-event interrupt status |
| wake_enable | input | 1 | Wake-event enable |
| od_mode | input | 1 | 1 selects open-drain drive |
| irq_out | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
Read data, including the master bit, follows source inputs in the same cycle. Bit 13 rises on the edge after the request falls or after a restart write, and falls exactly count × divider edges later. The pin changes one edge after its gated request. The bench drives inputs and samples outputs at the falling clock edge. A cycle-level model, written from these rules, predicts every output before the next rising edge. Directed checks land on the exact edge where each interval should end, and on the edge just before it.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;
  localparam int REG_W    = 32;
  localparam int IVL_W    = 8;
  localparam int IVL_LSB  = 24;
  localparam int CLR_BIT  = 14;
  localparam int STS_BIT  = 13;
  localparam int MST_BIT  = 12;
  localparam int EN_BIT   = 8;
  localparam int POL_BIT  = 4;
  // one interval unit is 10 us, i.e. a 100 kHz unit rate
  localparam int UNIT_HZ  = 100_000;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    tick_o = run_i && !restart_i && (pcnt_q == LAST);
    if (restart_i || !run_i || tick_o) pcnt_d = '0;
    else                               pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: units are at least two cycles apart
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kill_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         active_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = kill_i || load_i || (tick_i && active_o);
    if (kill_i)      cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  p_kill_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !active_o);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !kill_i) |=> (cnt_q == $past(load_val_i)));
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_i && !load_i && active_o) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_thr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             master_i,
  input  logic             active_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [IVL_W-1:0] ivl_o,
  output logic             en_o,
  output logic             pol_o,
  output logic             restart_o,
  output logic             zero_wr_o
);
  logic [IVL_W-1:0] ivl_d;
  logic             en_d, pol_d;
  logic [IVL_W-1:0] wr_ivl;

  always_comb begin
    wr_ivl    = wdata_i[IVL_LSB +: IVL_W];
    ivl_d     = wr_ivl;
    en_d      = wdata_i[EN_BIT];
    pol_d     = wdata_i[POL_BIT];
    restart_o = wr_i && wdata_i[CLR_BIT];
    zero_wr_o = wr_i && (wr_ivl == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_o <= '0;
      en_o  <= 1'b0;
      pol_o <= 1'b0;
    end else if (wr_i) begin
      ivl_o <= ivl_d;
      en_o  <= en_d;
      pol_o <= pol_d;
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[IVL_LSB +: IVL_W]     = ivl_o;
    rdata_o[STS_BIT]              = active_i;
    rdata_o[MST_BIT]              = master_i;
    rdata_o[EN_BIT]               = en_o;
    rdata_o[POL_BIT]              = pol_o;
  end

  p_field_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ivl_o == $past(wdata_i[IVL_LSB +: IVL_W])));
  p_field_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ivl_o) && $stable(en_o) && $stable(pol_o));
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic asrt_i,
  input  logic pol_i,
  input  logic od_i,
  output logic pin_o,
  output logic oe_o
);
  always_comb begin
    if (od_i) begin
      pin_o = 1'b0;
      oe_o  = asrt_i;
    end else begin
      pin_o = pol_i ? asrt_i : !asrt_i;
      oe_o  = 1'b1;
    end
  end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
  import irq_thr_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int CLK_FREQ_HZ = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [N_SRC-1:0] src_status,
  input  logic [N_SRC-1:0] src_enable,
  input  logic             wake_status,
  input  logic             wake_enable,
  input  logic             od_mode,
  output logic             irq_out,
  output logic             irq_oe
);
  localparam int DIV = CLK_FREQ_HZ / UNIT_HZ;

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             master, wake_hit, active, tick;
  logic             pin_req, fall, asrt_q;
  logic             restart, zero_wr, tmr_load;
  logic [IVL_W-1:0] ivl, load_val;
  logic             cfg_en, cfg_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    master   = |(src_status & src_enable);
    wake_hit = wake_status && wake_enable;
    pin_req  = cfg_en && ((master && !active) || wake_hit);
    fall     = asrt_q && !pin_req;
    tmr_load = restart || fall;
    load_val = restart ? reg_wdata[IVL_LSB +: IVL_W] : ivl;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) asrt_q <= 1'b0;
    else             asrt_q <= pin_req;
  end

  irq_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_i      (reg_wr),
    .wdata_i   (reg_wdata),
    .master_i  (master),
    .active_i  (active),
    .rdata_o   (reg_rdata),
    .ivl_o     (ivl),
    .en_o      (cfg_en),
    .pol_o     (cfg_pol),
    .restart_o (restart),
    .zero_wr_o (zero_wr)
  );

  irq_tick_gen #(.DIV(DIV)) u_tick (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .run_i     (active),
    .restart_i (tmr_load || zero_wr),
    .tick_o    (tick)
  );

  irq_holdoff_timer #(.W(IVL_W)) u_tmr (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .kill_i     (zero_wr),
    .load_i     (tmr_load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .active_o   (active)
  );

  irq_pin_drv u_drv (
    .asrt_i (asrt_q),
    .pol_i  (cfg_pol),
    .od_i   (od_mode),
    .pin_o  (irq_out),
    .oe_o   (irq_oe)
  );

  p_hold_back_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (active && !wake_hit) |-> !pin_req);
  p_en_off_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cfg_en |=> !asrt_q);
  p_wake_pass_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cfg_en && wake_hit) |=> asrt_q);
  p_od_low_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    od_mode |-> (!irq_out && (irq_oe == asrt_q)));
  p_pin_follow_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> (asrt_q == $past(pin_req)));
endmodule

// File: tb/irq_throttle_tb.sv
`timescale 1ns/1ps
module irq_throttle_tb;
  localparam int N   = 8;
  localparam int HZ  = 2_000_000;
  localparam int DIV = HZ / 100_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  src_status = '0;
  logic [N-1:0]  src_enable = '1;
  logic          wake_status = 1'b0;
  logic          wake_enable = 1'b1;
  logic          od_mode = 1'b0;
  logic          irq_out, irq_oe;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic       m_asrt = 1'b0;
  logic [7:0] m_cnt = '0, m_field = '0;
  int         m_pcnt = 0;
  logic       m_en = 1'b0, m_pol = 1'b0;

  always #2 clk = ~clk;

  irq_throttle #(.N_SRC(N), .CLK_FREQ_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_status(src_status), .src_enable(src_enable),
    .wake_status(wake_status), .wake_enable(wake_enable), .od_mode(od_mode),
    .irq_out(irq_out), .irq_oe(irq_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic f_master();
    return |(src_status & src_enable);
  endfunction

  function automatic logic f_req();
    return m_en && ((f_master() && (m_cnt == 0)) || (wake_status && wake_enable));
  endfunction

  function automatic logic [31:0] f_rdata();
    logic [31:0] r = '0;
    r[31:24] = m_field; r[13] = (m_cnt != 0); r[12] = f_master();
    r[8] = m_en; r[4] = m_pol;
    return r;
  endfunction

  function automatic logic [1:0] f_pin();
    if (od_mode) return {1'b0, m_asrt};
    return {(m_pol ? m_asrt : !m_asrt), 1'b1};
  endfunction

  task automatic model_edge(input logic wr, input logic [31:0] wd);
    logic req = f_req();
    if (wr && wd[31:24] == 0) begin
      m_cnt = 0; m_pcnt = 0;
    end else if (wr && wd[14]) begin
      m_cnt = wd[31:24]; m_pcnt = 0;
    end else if (m_asrt && !req) begin
      m_cnt = m_field; m_pcnt = 0;
    end else if (m_cnt != 0) begin
      if (m_pcnt == DIV - 1) begin m_pcnt = 0; m_cnt = m_cnt - 1; end
      else m_pcnt = m_pcnt + 1;
    end else m_pcnt = 0;
    m_asrt = req;
    if (wr) begin m_field = wd[31:24]; m_en = wd[8]; m_pol = wd[4]; end
  endtask

  // one cycle: apply inputs at the falling edge, compare with the model, advance
  task automatic step(input logic wr = 1'b0, input logic [31:0] wd = '0);
    reg_wr = wr; reg_wdata = wd;
    #1;
    chk("R1 register fields", {reg_rdata[31:24], reg_rdata[8], reg_rdata[4], reg_rdata[14]},
        {f_rdata()[31:24], f_rdata()[8], f_rdata()[4], 1'b0});
    chk("R2 master bit", reg_rdata[12], f_master());
    chk("R3 interval flag", reg_rdata[13], (m_cnt != 0));
    chk("R11 pin state", {irq_out, irq_oe}, f_pin());
    model_edge(wr, wd);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cfg(input logic [7:0] f, input logic en,
                                      input logic pol, input logic clr);
    logic [31:0] w = '0;
    w[31:24] = f; w[8] = en; w[4] = pol; w[14] = clr;
    return w;
  endfunction

  initial begin
    #(200_000 * 4);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", reg_rdata, 32'h0);
    chk("R8 reset pin idle high", {irq_out, irq_oe}, 2'b11);

    step(1'b1, cfg(8'd2, 1'b1, 1'b1, 1'b0));
    chk("R1 written value", reg_rdata, 32'h0200_0110);
    chk("R8 active-high idle", irq_out, 1'b0);

    src_status = 8'h01; step();
    chk("R11 pin asserts next edge", irq_out, 1'b1);
    chk("R2 master set", reg_rdata[12], 1'b1);

    src_status = 8'h00; step();
    chk("R3 interval starts", reg_rdata[13], 1'b1);
    src_status = 8'h01;
    repeat (2 * DIV - 1) step();
    chk("R4 held at last interval cycle", {reg_rdata[13], irq_out}, 2'b10);
    step();
    chk("R3 interval over", {reg_rdata[13], irq_out}, 2'b00);
    step();
    chk("R4 released after interval", irq_out, 1'b1);

    src_status = 8'h00; step();
    src_status = 8'h01;
    repeat (30) step();
    step(1'b1, cfg(8'd2, 1'b1, 1'b1, 1'b1));
    chk("R5 restart bit reads 0", reg_rdata[14], 1'b0);
    repeat (2 * DIV - 1) step();
    chk("R5 interval extended", {reg_rdata[13], irq_out}, 2'b10);
    step(); step();
    chk("R5 released after restart", irq_out, 1'b1);

    src_status = 8'h00; step();
    src_status = 8'h01;
    repeat (5) step();
    step(1'b1, cfg(8'd0, 1'b1, 1'b1, 1'b0));
    chk("R6 zero write ends interval", {reg_rdata[13], irq_out}, 2'b00);
    step();
    chk("R6 held request delivered", irq_out, 1'b1);
    step(1'b1, cfg(8'd3, 1'b1, 1'b1, 1'b0));

    src_status = 8'h00; step();
    src_status = 8'h01; wake_status = 1'b1; step();
    chk("R10 wake bypasses interval", {reg_rdata[13], irq_out}, 2'b11);
    wake_status = 1'b0;
    repeat (3 * DIV + 10) step();

    step(1'b1, cfg(8'd3, 1'b0, 1'b1, 1'b0));
    step();
    chk("R7 disabled pin deasserted", irq_out, 1'b0);
    chk("R2 master ignores enable", reg_rdata[12], 1'b1);

    step(1'b1, cfg(8'd3, 1'b1, 1'b0, 1'b0));
    od_mode = 1'b1; wake_status = 1'b1; step(); step();
    chk("R9 open-drain asserted", {irq_out, irq_oe}, 2'b01);
    wake_status = 1'b0; src_status = 8'h00; step();
    chk("R9 open-drain released", {irq_out, irq_oe}, 2'b00);
    od_mode = 1'b0; step();
    chk("R8 active-low idle", {irq_out, irq_oe}, 2'b11);

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      logic        w  = ($urandom % 16) == 0;
      logic [31:0] wd = cfg(8'($urandom % 4), ($urandom % 8) != 0,
                            1'($urandom), ($urandom % 3) == 0);
      if (($urandom % 6) == 0) src_status = N'($urandom);
      if (($urandom % 40) == 0) src_enable = N'($urandom);
      if (($urandom % 30) == 0) wake_status = (($urandom % 4) == 0);
      if (($urandom % 50) == 0) wake_enable = 1'($urandom);
      if (($urandom % 200) == 0) od_mode = 1'($urandom);
      step(w, wd);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule